// File: doc/BRIEF.md
# Double-Buffered Single-Channel PWM Generator

This block makes one pulse-width-modulated output from an up-counting timebase. Software programs it over a simple write/read register bus. Each period is set by a 32-bit period register and each pulse by a 32-bit compare register. Each of these active registers has a shadow partner. Values written to a shadow wait until the running period ends, so a new configuration never cuts a period short. The active registers may also be written directly. This is the normal way to set the block up while the counter is halted.

A 16-bit control register does four things. It starts or halts the counter, enables the PWM drive, selects output polarity, and holds a two-bit sync-disable field. The block has no sync input, so that field is only stored. A small two-state machine follows the run bit. In state ST_STOP the counter holds its value. In state ST_RUN it counts up and wraps. Transition GO takes ST_STOP to ST_RUN when the registered run bit is 1. Transition HALT takes ST_RUN back to ST_STOP when the bit is 0. Any other combination leaves the state as it is.

Top module: `shpwm_top`

## Requirements
- R1: After reset, every register reads 0, the counter is 0 in state ST_STOP, and the output is low.
- R2: Byte offsets: 0x08 active period, 0x0C active compare, 0x10 shadow period, 0x14 shadow compare, 0x2A control (written and read through data bits 15:0, with bits 31:16 reading 0). Each register reads back its current contents. Any other offset reads 0. Control bits 7:6 are stored and have no effect on the output or the counter.
- R3: Control bit 4 is the run bit. The state machine samples it on each clock, and the counter advances only while the state is ST_RUN. Counting therefore begins on the second clock edge after the write that sets the bit. While the state is ST_STOP the count holds.
- R4: In ST_RUN the counter counts up from 0. On a clock where the count is greater than or equal to the active period, the count becomes 0 instead. That clock is called the wrap.
- R5: A shadow write sets that shadow's pending flag. A wrap copies each pending shadow into its active register and clears the flag. An active register without a pending shadow is left unchanged. A shadow write made on the wrap clock stays pending until the next wrap.
- R6: A direct write to an active register takes effect on the next clock, whether the counter is running or not. It takes priority over a shadow transfer on the same clock.
- R7: When control bit 10 is 0, the output is high while the count is below the active compare value. A compare of 0 gives a constantly low output, and a compare above the period gives a constantly high output.
- R8: When control bit 10 is 1, the output is the complement of the R7 waveform.
- R9: When control bit 9 (PWM enable) is 0, the output is low regardless of the count, the compare value and the polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 6 | Byte offset for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
Directed runs first program a mid-range compare inside a short period to show the basic high-then-low shape. They then try compares of 0 and above the period, which separate the strict less-than test from an off-by-one. Polarity toggles, enable-off and run-off sequences show inversion, forced low and a held count. They also show that the sync-disable field has no effect. A shadow write in mid-period is read back through the active offset before and after the wrap, which separates deferred transfer from immediate update. Random writes with small periods then collide shadow writes, direct writes and wraps on the same clock, and the output is compared on every cycle against a cycle model written from the requirements.

// File: rtl/shpwm_pkg.sv
package shpwm_pkg;
    typedef enum logic [0:0] {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int OFS_ACT_PER = 'h08;
    localparam int OFS_ACT_CMP = 'h0C;
    localparam int OFS_SH_PER  = 'h10;
    localparam int OFS_SH_CMP  = 'h14;
    localparam int OFS_CTL     = 'h2A;

    localparam int BIT_RUN  = 4;
    localparam int BIT_MODE = 9;
    localparam int BIT_POL  = 10;
endpackage

// File: rtl/shpwm_regs.sv
module shpwm_regs
    import shpwm_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wrap,
    output logic [DW-1:0] act_per,
    output logic [DW-1:0] act_cmp,
    output logic [CW-1:0] ctl,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] sh_per, sh_cmp;
    logic          pend_per, pend_cmp;
    logic          wr_ap, wr_ac, wr_sp, wr_sc, wr_ctl;

    assign wr_ap  = wr_en && (addr == AW'(OFS_ACT_PER));
    assign wr_ac  = wr_en && (addr == AW'(OFS_ACT_CMP));
    assign wr_sp  = wr_en && (addr == AW'(OFS_SH_PER));
    assign wr_sc  = wr_en && (addr == AW'(OFS_SH_CMP));
    assign wr_ctl = wr_en && (addr == AW'(OFS_CTL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_per   <= '0;
            sh_cmp   <= '0;
            pend_per <= 1'b0;
            pend_cmp <= 1'b0;
            act_per  <= '0;
            act_cmp  <= '0;
            ctl      <= '0;
        end else begin
            if (wr_sp) begin
                sh_per   <= wdata;
                pend_per <= 1'b1;
            end else if (wrap) begin
                pend_per <= 1'b0;
            end
            if (wr_sc) begin
                sh_cmp   <= wdata;
                pend_cmp <= 1'b1;
            end else if (wrap) begin
                pend_cmp <= 1'b0;
            end
            if (wr_ap)                  act_per <= wdata;
            else if (wrap && pend_per)  act_per <= sh_per;
            if (wr_ac)                  act_cmp <= wdata;
            else if (wrap && pend_cmp)  act_cmp <= sh_cmp;
            if (wr_ctl)                 ctl <= wdata[CW-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_ACT_PER))      rdata = act_per;
        else if (addr == AW'(OFS_ACT_CMP)) rdata = act_cmp;
        else if (addr == AW'(OFS_SH_PER))  rdata = sh_per;
        else if (addr == AW'(OFS_SH_CMP))  rdata = sh_cmp;
        else if (addr == AW'(OFS_CTL))     rdata = DW'(ctl);
    end

    // R5: without a wrap or direct write, the active period holds
    a_r5_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !wr_ap) |=> $stable(act_per));

    // R5: a pending shadow is moved in at the wrap
    a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pend_cmp && !wr_ac) |=> (act_cmp == $past(sh_cmp)));

    // R6: a direct write beats the transfer
    a_r6_direct_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ap |=> (act_per == $past(wdata)));
endmodule

// File: rtl/shpwm_ctr.sv
module shpwm_ctr
    import shpwm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic [DW-1:0] act_per,
    output logic [DW-1:0] cnt,
    output logic          wrap
);
    run_state_e state_q, state_d;

    // next-state logic: GO and HALT transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run_req)  state_d = ST_RUN;
            ST_RUN:  if (!run_req) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // counter, driven by the state
    assign wrap = (state_q == ST_RUN) && (cnt >= act_per);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (wrap)              cnt <= '0;
        else if (state_q == ST_RUN) cnt <= cnt + 1'b1;
    end

    // R3: count holds while stopped
    a_r3_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |=> $stable(cnt));

    // R4: running below period increments by one
    a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt < act_per) |=> (cnt == $past(cnt) + 1'b1));

    // R4: reaching the period returns to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt >= act_per) |=> (cnt == '0));
endmodule

// File: rtl/shpwm_top.sv
module shpwm_top
    import shpwm_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          pwm_out
);
    logic [DW-1:0] act_per, act_cmp, cnt;
    logic [CW-1:0] ctl;
    logic          wrap;

    shpwm_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .wrap(wrap), .act_per(act_per), .act_cmp(act_cmp), .ctl(ctl),
        .rdata(rdata)
    );

    shpwm_ctr #(.DW(DW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .run_req(ctl[BIT_RUN]), .act_per(act_per),
        .cnt(cnt), .wrap(wrap)
    );

    // output process
    always_comb begin
        pwm_out = 1'b0;
        if (ctl[BIT_MODE]) pwm_out = ctl[BIT_POL] ^ (cnt < act_cmp);
    end

    // R9: disabled drive means low output
    a_r9_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[BIT_MODE] |-> !pwm_out);

    // R7: compare of zero with normal polarity is never high
    a_r7_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmp == '0 && !ctl[BIT_POL]) |-> !pwm_out);
endmodule

// File: tb/shpwm_top_bench.sv
module shpwm_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    // model state
    logic [31:0] m_aper = 0, m_acmp = 0, m_sper = 0, m_scmp = 0, m_cnt = 0;
    logic [15:0] m_ctl = 0;
    logic        m_pp = 0, m_pc = 0, m_run = 0;

    shpwm_top u_shpwm_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h08:   return m_aper;
            6'h0C:   return m_acmp;
            6'h10:   return m_sper;
            6'h14:   return m_scmp;
            6'h2A:   return {16'h0, m_ctl};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_out();
        if (!m_ctl[9]) return 1'b0;
        return m_ctl[10] ^ (m_cnt < m_acmp);
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            logic w, ap, ac, sp, sc, cw;
            logic [31:0] n_cnt;
            w  = m_run && (m_cnt >= m_aper);
            ap = wr_en && addr == 6'h08;
            ac = wr_en && addr == 6'h0C;
            sp = wr_en && addr == 6'h10;
            sc = wr_en && addr == 6'h14;
            cw = wr_en && addr == 6'h2A;
            n_cnt = w ? 32'h0 : (m_run ? m_cnt + 1 : m_cnt);
            if (ap) m_aper = wdata; else if (w && m_pp) m_aper = m_sper;
            if (ac) m_acmp = wdata; else if (w && m_pc) m_acmp = m_scmp;
            if (sp) begin m_sper = wdata; m_pp = 1'b1; end else if (w) m_pp = 1'b0;
            if (sc) begin m_scmp = wdata; m_pc = 1'b1; end else if (w) m_pc = 1'b0;
            m_run = m_ctl[4];
            if (cw) m_ctl = wdata[15:0];
            m_cnt = n_cnt;
        end
    end

    task automatic check_now();
        checks++;
        if (pwm_out !== exp_out()) begin
            errors++;
            $display("FAIL %s pwm_out act=%0b exp=%0b t=%0t", cur_req, pwm_out, exp_out(), $time);
        end
        checks++;
        if (rdata !== exp_rd(addr)) begin
            errors++;
            $display("FAIL %s rdata@%h act=%h exp=%h t=%0t", cur_req, addr, rdata, exp_rd(addr), $time);
        end
    endtask

    // drive, clock, sample at negedge
    task automatic step(input logic we, input logic [5:0] a, input logic [31:0] d);
        wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check_now();
    endtask

    task automatic idle(input int n, input logic [5:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 32'h0);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd2024;
        logic [5:0] alist [6] = '{6'h08, 6'h0C, 6'h10, 6'h14, 6'h2A, 6'h20};
        void'($urandom(seed));
        // R1 reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        foreach (alist[i]) begin addr = alist[i]; #1; check_now(); end
        rst_n = 1'b1;
        @(negedge clk);
        // R2 readback and unused offsets, sync field stored only
        cur_req = "R2";
        step(1'b1, 6'h10, 32'hA5A5_0003); idle(1, 6'h10);
        step(1'b1, 6'h14, 32'h1234_5678); idle(1, 6'h14);
        step(1'b1, 6'h2A, 32'hFFFF_00C0); idle(1, 6'h2A);
        idle(2, 6'h20);
        step(1'b1, 6'h08, 32'd5); step(1'b1, 6'h0C, 32'd2); idle(1, 6'h0C);
        step(1'b1, 6'h10, 32'd5); step(1'b1, 6'h14, 32'd2);
        // R3 start counting, R7 basic shape
        cur_req = "R3";
        step(1'b1, 6'h2A, 32'h0000_02D0); idle(4, 6'h08);
        cur_req = "R7";
        idle(14, 6'h0C);
        // R5 shadow deferred until wrap
        cur_req = "R5";
        step(1'b1, 6'h10, 32'd9); idle(8, 6'h08);
        step(1'b1, 6'h14, 32'd4); idle(12, 6'h0C);
        // R8 inverted polarity
        cur_req = "R8";
        step(1'b1, 6'h2A, 32'h0000_06D0); idle(12, 6'h2A);
        // R9 forced low
        cur_req = "R9";
        step(1'b1, 6'h2A, 32'h0000_0410); idle(10, 6'h2A);
        // R3 halt holds
        cur_req = "R3";
        step(1'b1, 6'h2A, 32'h0000_0200); idle(8, 6'h08);
        // R6 direct write while stopped
        cur_req = "R6";
        step(1'b1, 6'h08, 32'd3); idle(1, 6'h08);
        step(1'b1, 6'h0C, 32'd0); idle(1, 6'h0C);
        // R7 zero duty then full duty
        cur_req = "R7";
        step(1'b1, 6'h2A, 32'h0000_0210); idle(10, 6'h0C);
        step(1'b1, 6'h0C, 32'd7); idle(10, 6'h0C);
        // R4 random traffic with colliding writes and wraps
        cur_req = "R4";
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] a;
            logic [31:0] d;
            a = alist[$urandom_range(5, 0)];
            d = (a == 6'h2A) ? ($urandom() | 32'h10) & ~32'h0 : 32'($urandom_range(12, 0));
            if (a == 6'h2A && $urandom_range(7, 0) == 0) d = d & ~32'h10;
            if ($urandom_range(3, 0) == 0) step(1'b1, a, d);
            else step(1'b0, alist[$urandom_range(5, 0)], 32'h0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule